// File: doc/BRIEF.md
# Two-Port Address Collision Arbiter

This block sits next to a shared memory that has two independent access ports, left and right. Each port has an active-low select, an address and a write request. When both ports are selected on the same address in the same cycle, the block lets one port through. It pulls the other port's active-low busy line low and masks that port's write strobe to the memory. A read made by the held-off port is marked as invalid so that the requester can retry it. All decisions are made on a single clock. An event that lands in the same cycle on both ports counts as simultaneous.

The winner depends on which condition came last. If both ports were already selected and the addresses then came to agree, the port whose address has been steady the longest wins. If the addresses were already equal, or a select arrived together with the match, the port that has been selected the longest wins. Equal history goes to the left port. The grant is held for as long as the collision lasts. The collision ends when the winner drops its select or moves to another address. In that same cycle the loser's busy line is released and its write goes through.

A role input sets how several of these blocks work side by side on a wider data bus. In master role the block arbitrates and drives both busy outputs. In slave role it does not arbitrate: its busy outputs stay high, and two busy inputs, fed from a master, only gate the local writes and mark the local reads.

Top module: `dpc_collision_arb`

## Requirements
- R1: While reset is held, and after it is released with both ports deselected, both busy outputs are high (inactive), no port is granted, and no memory write strobe is active.
- R2: With the role input high (master), when the ports are not both selected (select low) or their addresses differ, both busy outputs stay high and each selected port's write request passes to its memory write output in the same cycle.
- R3: In master role, if both ports were selected in the previous cycle and their addresses become equal, the port whose address has been unchanged for more cycles wins. The loser's busy output goes low in the same cycle.
- R4: In master role, if a collision starts while at least one port was not selected in the previous cycle, the port that has been selected for more consecutive cycles wins. The loser's busy output goes low in the same cycle.
- R5: When both ports have the same history, the left port wins. Examples are both selecting in the same cycle, or both addresses changing to the same value in one cycle. Only the right busy output goes low, and the two busy outputs are never low together.
- R6: A grant stays with the same port while the collision lasts. The loser's busy output returns high in the first cycle in which the winner is deselected or its address differs.
- R7: A port whose effective busy is low never drives its memory write output high, while the winning port's write request passes unchanged.
- R8: A selected port that is reading (write request low) while its effective busy is low raises its invalid-read output. A read with busy high does not raise it.
- R9: In master role the busy inputs have no effect. In slave role (role input low) both busy outputs stay high whatever the addresses, and colliding writes on both ports pass.
- R10: In slave role a low busy input masks that port's memory write and marks its read as invalid. A high busy input lets the port's access through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_master | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (busy inputs only gate) |
| l_sel_n | input | 1 | Left port select, active low |
| l_addr | input | AW | Left port address |
| l_we | input | 1 | Left port write request, 1 = write, 0 = read |
| l_busy_in_n | input | 1 | Left busy from a master, active low, used in slave role |
| r_sel_n | input | 1 | Right port select, active low |
| r_addr | input | AW | Right port address |
| r_we | input | 1 | Right port write request, 1 = write, 0 = read |
| r_busy_in_n | input | 1 | Right busy from a master, active low, used in slave role |
| l_busy_n | output | 1 | Left busy, active low, driven in master role |
| r_busy_n | output | 1 | Right busy, active low, driven in master role |
| l_mem_we | output | 1 | Gated left write strobe to the memory |
| r_mem_we | output | 1 | Gated right write strobe to the memory |
| l_rd_bad | output | 1 | Left read made while held off |
| r_rd_bad | output | 1 | Right read made while held off |

## Verification
The hardest situations to reach are the ones where the two kinds of history disagree. In one, the addresses come to match while both ports have long been selected, so address age decides. In another, a port selects onto an address that already matches, so select age decides. In a third, both histories are equal and the fixed left preference must apply. The stimulus builds each history on purpose: it holds one address steady while the other port moves onto it, it selects one port several cycles before the other on a shared address, and it changes both addresses or both selects in one cycle. It then releases the winner to show the busy line clearing. A behavioural model, built from counts of cycles since each event, is compared on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_t;

   localparam int PORTS = 2;
   localparam int P_L   = 0;
   localparam int P_R   = 1;
endpackage

// File: rtl/dpc_age.sv
// Saturating count of consecutive cycles over which a condition has held.
// The count is zero in the first cycle of the condition.
module dpc_age #(
   parameter int AGE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont,
   output logic [AGE_W-1:0] age
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;
   localparam logic [AGE_W-1:0] AGE_ONE = 1;

   logic [AGE_W-1:0] cnt_q;

   always_comb begin
      if (!cont)                age = '0;
      else if (cnt_q == AGE_MAX) age = AGE_MAX;
      else                      age = cnt_q + AGE_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= age;
   end
endmodule

// File: rtl/dpc_pick.sv
// Chooses the winner of a newly starting collision from event ages.
module dpc_pick #(
   parameter int AGE_W     = 4,
   parameter bit TIE_RIGHT = 1'b0
) (
   input  logic [1:0]            prev_sel,
   input  logic [1:0][AGE_W-1:0] sel_age,
   input  logic [1:0][AGE_W-1:0] addr_age,
   output logic                  win_right
);
   logic [AGE_W-1:0] age_l, age_r;

   // Both ports selected before: the address match is the late event.
   always_comb begin
      if (&prev_sel) begin
         age_l = addr_age[0];
         age_r = addr_age[1];
      end else begin
         age_l = sel_age[0];
         age_r = sel_age[1];
      end
   end

   generate
      if (TIE_RIGHT) begin : g_tie_r
         assign win_right = (age_r >= age_l);
      end else begin : g_tie_l
         assign win_right = (age_r > age_l);
      end
   endgenerate
endmodule

// File: rtl/dpc_gate.sv
// Per-port masking of the write strobe and marking of held-off reads.
module dpc_gate (
   input  logic sel,
   input  logic we,
   input  logic busy_n,
   output logic mem_we,
   output logic rd_bad
);
   assign mem_we = sel & we & busy_n;
   assign rd_bad = sel & ~we & ~busy_n;
endmodule

// File: rtl/dpc_collision_arb.sv
module dpc_collision_arb
   import dpc_pkg::*;
#(
   parameter int AW        = 13,
   parameter int AGE_W     = 4,
   parameter bit TIE_RIGHT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          role_master,
   input  logic          l_sel_n,
   input  logic [AW-1:0] l_addr,
   input  logic          l_we,
   input  logic          l_busy_in_n,
   input  logic          r_sel_n,
   input  logic [AW-1:0] r_addr,
   input  logic          r_we,
   input  logic          r_busy_in_n,
   output logic          l_busy_n,
   output logic          r_busy_n,
   output logic          l_mem_we,
   output logic          r_mem_we,
   output logic          l_rd_bad,
   output logic          r_rd_bad
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("dpc_collision_arb: AW must be at least 1");
      end
      if (AGE_W < 1) begin : g_bad_age
         $error("dpc_collision_arb: AGE_W must be at least 1");
      end
   endgenerate

   logic [PORTS-1:0]                sel, sel_q, we_v, busy_in_v;
   logic [PORTS-1:0]                lose, eff_busy_n, mem_we_v, rd_bad_v;
   logic [PORTS-1:0][AW-1:0]        addr_v, addr_q;
   logic [PORTS-1:0][AGE_W-1:0]     sel_age, addr_age;
   logic                            conflict, new_win_right;
   own_t                            owner_q, owner_d;

   assign sel       = {~r_sel_n, ~l_sel_n};
   assign we_v      = {r_we, l_we};
   assign busy_in_v = {r_busy_in_n, l_busy_in_n};
   assign addr_v    = {r_addr, l_addr};

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         dpc_age #(.AGE_W(AGE_W)) u_sel_age (
            .clk   (clk),
            .rst_n (rst_n),
            .cont  (sel[p] & sel_q[p]),
            .age   (sel_age[p])
         );
         dpc_age #(.AGE_W(AGE_W)) u_addr_age (
            .clk   (clk),
            .rst_n (rst_n),
            .cont  (addr_v[p] == addr_q[p]),
            .age   (addr_age[p])
         );
         assign eff_busy_n[p] = role_master ? ~lose[p] : busy_in_v[p];
         dpc_gate u_gate (
            .sel    (sel[p]),
            .we     (we_v[p]),
            .busy_n (eff_busy_n[p]),
            .mem_we (mem_we_v[p]),
            .rd_bad (rd_bad_v[p])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         addr_q <= '0;
      end else begin
         sel_q  <= sel;
         addr_q <= addr_v;
      end
   end

   assign conflict = (&sel) && (addr_v[P_L] == addr_v[P_R]);

   dpc_pick #(.AGE_W(AGE_W), .TIE_RIGHT(TIE_RIGHT)) u_pick (
      .prev_sel  (sel_q),
      .sel_age   (sel_age),
      .addr_age  (addr_age),
      .win_right (new_win_right)
   );

   always_comb begin
      lose = '0;
      if (role_master && conflict) begin
         unique case (owner_q)
            OWN_LEFT:  lose = 2'b10;
            OWN_RIGHT: lose = 2'b01;
            default:   lose = new_win_right ? 2'b01 : 2'b10;
         endcase
      end
   end

   always_comb begin
      owner_d = owner_q;
      if (!role_master || !conflict) owner_d = OWN_NONE;
      else if (owner_q == OWN_NONE)  owner_d = new_win_right ? OWN_RIGHT : OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end

   assign l_busy_n = ~lose[P_L];
   assign r_busy_n = ~lose[P_R];
   assign l_mem_we = mem_we_v[P_L];
   assign r_mem_we = mem_we_v[P_R];
   assign l_rd_bad = rd_bad_v[P_L];
   assign r_rd_bad = rd_bad_v[P_R];
endmodule

// File: rtl/dpc_collision_chk.sv
module dpc_collision_chk #(
   parameter int AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          role_master,
   input logic          l_sel_n,
   input logic [AW-1:0] l_addr,
   input logic          l_busy_in_n,
   input logic          r_sel_n,
   input logic [AW-1:0] r_addr,
   input logic          r_busy_in_n,
   input logic          l_busy_n,
   input logic          r_busy_n,
   input logic          l_mem_we,
   input logic          r_mem_we
);
   logic clash;
   assign clash = !l_sel_n && !r_sel_n && (l_addr == r_addr);

   // R5
   busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n && !r_busy_n));

   // R2
   busy_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_busy_n || !r_busy_n) |-> (clash && role_master));

   // R6
   grant_hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_master && !r_busy_n) |=> (!(role_master && clash) || !r_busy_n));

   // R6
   grant_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_master && !l_busy_n) |=> (!(role_master && clash) || !l_busy_n));

   // R7
   loser_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      role_master |-> (!(!l_busy_n && l_mem_we) && !(!r_busy_n && r_mem_we)));

   // R9
   slave_busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !role_master |-> (l_busy_n && r_busy_n));

   // R10
   slave_input_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !role_master |-> (!(!l_busy_in_n && l_mem_we) && !(!r_busy_in_n && r_mem_we)));
endmodule

bind dpc_collision_arb dpc_collision_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .role_master (role_master),
   .l_sel_n     (l_sel_n),
   .l_addr      (l_addr),
   .l_busy_in_n (l_busy_in_n),
   .r_sel_n     (r_sel_n),
   .r_addr      (r_addr),
   .r_busy_in_n (r_busy_in_n),
   .l_busy_n    (l_busy_n),
   .r_busy_n    (r_busy_n),
   .l_mem_we    (l_mem_we),
   .r_mem_we    (r_mem_we)
);

// File: tb/tb_dpc_collision_arb.sv
`timescale 1ns/1ps
module tb_dpc_collision_arb;
   localparam int AW    = 13;
   localparam int AGE_W = 4;
   localparam int MAXA  = (1 << AGE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic role_master = 1'b1;
   logic l_sel_n = 1'b1, r_sel_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_we = 1'b0, r_we = 1'b0;
   logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
   logic l_busy_n, r_busy_n, l_mem_we, r_mem_we, l_rd_bad, r_rd_bad;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   int            m_sage [2];
   int            m_aage [2];
   bit            m_psel [2];
   logic [AW-1:0] m_paddr[2];
   int            m_owner;   // 0 none, 1 left, 2 right

   always #2 clk = ~clk;

   dpc_collision_arb #(.AW(AW), .AGE_W(AGE_W)) dut (
      .clk(clk), .rst_n(rst_n), .role_master(role_master),
      .l_sel_n(l_sel_n), .l_addr(l_addr), .l_we(l_we), .l_busy_in_n(l_busy_in_n),
      .r_sel_n(r_sel_n), .r_addr(r_addr), .r_we(r_we), .r_busy_in_n(r_busy_in_n),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
      .l_mem_we(l_mem_we), .r_mem_we(r_mem_we),
      .l_rd_bad(l_rd_bad), .r_rd_bad(r_rd_bad)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic drive(input logic ls, input int la, input logic lw,
                        input logic rs, input int ra, input logic rw);
      l_sel_n = ls; l_addr = la[AW-1:0]; l_we = lw;
      r_sel_n = rs; r_addr = ra[AW-1:0]; r_we = rw;
      #1;
   endtask

   function automatic int sat1(input int v);
      return (v + 1 > MAXA) ? MAXA : v + 1;
   endfunction

   // Compare against the model, then advance one clock.
   task automatic step(input string tag);
      bit sel[2];
      logic [AW-1:0] ad[2];
      logic wv[2], bin[2];
      int sa[2], aa[2];
      bit clash, wr, lose_l, lose_r, eb_l, eb_r;
      int na, nb;
      sel[0] = !l_sel_n; sel[1] = !r_sel_n;
      ad[0] = l_addr; ad[1] = r_addr;
      wv[0] = l_we; wv[1] = r_we;
      bin[0] = l_busy_in_n; bin[1] = r_busy_in_n;
      for (int i = 0; i < 2; i++) begin
         sa[i] = (sel[i] && m_psel[i]) ? sat1(m_sage[i]) : 0;
         aa[i] = (ad[i] == m_paddr[i]) ? sat1(m_aage[i]) : 0;
      end
      clash = sel[0] && sel[1] && (ad[0] == ad[1]);
      if (m_psel[0] && m_psel[1]) begin na = aa[0]; nb = aa[1]; end
      else begin na = sa[0]; nb = sa[1]; end
      wr = (nb > na);
      lose_l = 1'b0; lose_r = 1'b0;
      if (role_master && clash) begin
         if (m_owner == 1)      lose_r = 1'b1;
         else if (m_owner == 2) lose_l = 1'b1;
         else if (wr)           lose_l = 1'b1;
         else                   lose_r = 1'b1;
      end
      eb_l = role_master ? !lose_l : bin[0];
      eb_r = role_master ? !lose_r : bin[1];
      chk(tag, "model l_busy_n", l_busy_n, !lose_l);
      chk(tag, "model r_busy_n", r_busy_n, !lose_r);
      chk(tag, "model l_mem_we", l_mem_we, sel[0] && wv[0] && eb_l);
      chk(tag, "model r_mem_we", r_mem_we, sel[1] && wv[1] && eb_r);
      chk(tag, "model l_rd_bad", l_rd_bad, sel[0] && !wv[0] && !eb_l);
      chk(tag, "model r_rd_bad", r_rd_bad, sel[1] && !wv[1] && !eb_r);
      @(posedge clk);
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_sage[i] = 0; m_aage[i] = 0; m_psel[i] = 1'b0; m_paddr[i] = '0;
         end
         m_owner = 0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            m_sage[i] = sa[i]; m_aage[i] = aa[i]; m_psel[i] = sel[i]; m_paddr[i] = ad[i];
         end
         if (!role_master || !clash) m_owner = 0;
         else if (m_owner == 0)      m_owner = wr ? 2 : 1;
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_sage[i] = 0; m_aage[i] = 0; m_psel[i] = 1'b0; m_paddr[i] = '0;
      end
      m_owner = 0;
      @(negedge clk);
      // R1: reset state
      drive(1, 0, 1, 1, 0, 1);
      chk("R1", "l_busy_n in reset", l_busy_n, 1'b1);
      chk("R1", "r_busy_n in reset", r_busy_n, 1'b1);
      chk("R1", "l_mem_we in reset", l_mem_we, 1'b0);
      repeat (3) step("R1");
      rst_n = 1'b1; #1;
      step("R1");
      chk("R1", "r_busy_n after reset", r_busy_n, 1'b1);

      // R2: different addresses, and one side deselected on the same address
      drive(0, 100, 1, 0, 200, 1);
      chk("R2", "l_mem_we distinct addr", l_mem_we, 1'b1);
      chk("R2", "r_mem_we distinct addr", r_mem_we, 1'b1);
      chk("R2", "l_busy_n distinct addr", l_busy_n, 1'b1);
      repeat (3) step("R2");
      drive(0, 300, 1, 1, 300, 1);
      chk("R2", "r_busy_n right deselected", r_busy_n, 1'b1);
      chk("R2", "l_mem_we right deselected", l_mem_we, 1'b1);
      step("R2");

      // R3: both selected, right moves onto left's steady address -> left wins
      drive(0, 300, 1, 0, 5, 0);
      repeat (3) step("R3");
      drive(0, 300, 1, 0, 300, 1);
      chk("R3", "r_busy_n right moved onto left", r_busy_n, 1'b0);
      chk("R3", "l_busy_n winner", l_busy_n, 1'b1);
      chk("R7", "r_mem_we masked", r_mem_we, 1'b0);
      chk("R7", "l_mem_we winner passes", l_mem_we, 1'b1);
      repeat (2) step("R6");
      chk("R6", "r_busy_n held", r_busy_n, 1'b0);
      // R6: winner leaves, loser released in the same cycle
      drive(1, 300, 0, 0, 300, 1);
      chk("R6", "r_busy_n released", r_busy_n, 1'b1);
      chk("R6", "r_mem_we after release", r_mem_we, 1'b1);
      step("R6");

      // R3: left moves onto right's steady address -> right wins
      drive(0, 50, 0, 0, 300, 0);
      repeat (3) step("R3");
      drive(0, 300, 0, 0, 300, 0);
      chk("R3", "l_busy_n left moved onto right", l_busy_n, 1'b0);
      chk("R3", "r_busy_n winner", r_busy_n, 1'b1);
      chk("R8", "l_rd_bad held-off read", l_rd_bad, 1'b1);
      chk("R8", "r_rd_bad winner read", r_rd_bad, 1'b0);
      repeat (2) step("R8");
      drive(1, 0, 0, 1, 0, 0);
      repeat (2) step("R2");

      // R4: right selected first on a shared address, left joins later
      drive(1, 77, 0, 0, 77, 0);
      repeat (3) step("R4");
      drive(0, 77, 1, 0, 77, 1);
      chk("R4", "l_busy_n late select", l_busy_n, 1'b0);
      chk("R4", "r_busy_n early select", r_busy_n, 1'b1);
      chk("R7", "l_mem_we masked", l_mem_we, 1'b0);
      chk("R7", "r_mem_we passes", r_mem_we, 1'b1);
      repeat (3) step("R4");
      // R6: right moves away, left freed
      drive(0, 77, 1, 0, 78, 1);
      chk("R6", "l_busy_n freed on address move", l_busy_n, 1'b1);
      chk("R6", "l_mem_we freed", l_mem_we, 1'b1);
      step("R6");
      drive(1, 0, 0, 1, 0, 0);
      repeat (2) step("R5");

      // R5: both select in the same cycle on the same address
      drive(0, 88, 1, 0, 88, 1);
      chk("R5", "r_busy_n tie select", r_busy_n, 1'b0);
      chk("R5", "l_busy_n tie select", l_busy_n, 1'b1);
      step("R5");
      drive(0, 1, 0, 0, 2, 0);
      repeat (3) step("R5");
      // R5: both addresses change to one value together
      drive(0, 9, 1, 0, 9, 1);
      chk("R5", "r_busy_n tie address", r_busy_n, 1'b0);
      chk("R5", "l_mem_we tie address", l_mem_we, 1'b1);
      step("R5");
      drive(1, 0, 0, 1, 0, 0);
      step("R5");

      // R9: slave role, no arbitration
      role_master = 1'b0;
      drive(0, 40, 1, 0, 40, 1);
      chk("R9", "l_busy_n slave", l_busy_n, 1'b1);
      chk("R9", "r_busy_n slave", r_busy_n, 1'b1);
      chk("R9", "l_mem_we slave collide", l_mem_we, 1'b1);
      chk("R9", "r_mem_we slave collide", r_mem_we, 1'b1);
      repeat (2) step("R9");
      // R10: busy input gates
      l_busy_in_n = 1'b0;
      drive(0, 40, 1, 0, 40, 1);
      chk("R10", "l_mem_we blocked by input", l_mem_we, 1'b0);
      chk("R10", "r_mem_we passes", r_mem_we, 1'b1);
      step("R10");
      drive(0, 40, 0, 0, 41, 1);
      chk("R10", "l_rd_bad by input", l_rd_bad, 1'b1);
      step("R10");
      l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
      drive(0, 40, 1, 0, 41, 1);
      chk("R10", "l_mem_we released input", l_mem_we, 1'b1);
      chk("R10", "r_mem_we blocked by input", r_mem_we, 1'b0);
      step("R10");
      drive(1, 0, 0, 1, 0, 0);
      step("R10");

      // R9: master ignores busy inputs
      role_master = 1'b1;
      l_busy_in_n = 1'b0; r_busy_in_n = 1'b0;
      drive(0, 10, 1, 0, 11, 1);
      chk("R9", "l_mem_we master ignores input", l_mem_we, 1'b1);
      chk("R9", "r_mem_we master ignores input", r_mem_we, 1'b1);
      repeat (2) step("R9");
      drive(1, 0, 0, 1, 0, 0);
      step("R9");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule